// File: doc/BRIEF.md
# Run-Length Sample Compressor and Packetizer

This block sits behind the input stage of a multi-channel capture path. While capture is enabled it accepts one 16-bit sample per clock and folds runs of equal samples into 24-bit records, each holding the sample value and a count of extra repeats. Records are gathered five at a time. A sequence byte is appended to each group, which gives one 128-bit packet. Each packet goes out as a single word on a valid/ready port, sized to match one 16-byte memory burst.

When capture ends, the controller pulses a flush request. The block then closes the open run and tops up any partial packet with padding records, so the downstream side only ever sees whole packets. If the downstream side stops taking packets, the block lowers its sample-ready output. The source waits while ready is low, so no sample is lost.

Top module: `rle_sample_packer`

## Requirements
- R1: A record is 24 bits. Bits [15:0] hold the sample value and bits [23:16] hold the number of extra repeats (0 to 255). In byte terms the record is value low byte, value high byte, then count.
- R2: A sample equal to the open run's value extends that run. A different sample closes the run's record and opens a new run with count 0.
- R3: A run that has reached count 255 cannot grow. The next equal sample closes it as a record with count 255 and opens a new run of the same value with count 0. Exactly 256 equal samples therefore give one record with count 255.
- R4: A packet is 128 bits. Record k (k = 0 to 4, in the order the records were closed) occupies bits [24k+23:24k], and bits [127:120] hold the sequence byte.
- R5: The sequence byte is 0 in the first packet after reset. It rises by one in each later packet and wraps from 255 to 0.
- R6: A flush request, taken only while `cap_en` is low and `smp_rdy` is high, closes the open run as a record. It then fills the rest of a partial packet with records that carry the last record's value and count 0. Sample input is held off (`smp_rdy` low) until the packet is complete.
- R7: While `pkt_valid` is high and `pkt_ready` is low, `pkt_data` and `pkt_valid` hold. Samples offered while `smp_rdy` is low are not taken, and every accepted sample is represented in the output.
- R8: After reset, `pkt_valid` is low and `smp_rdy` is high.
- R9: Cycles with `cap_en` low, whatever is on `smp_in`, add nothing to any run.
- R10: A flush with no open run and no partial packet produces no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Sample on `smp_in` is valid this cycle |
| smp_in | input | 16 | Input sample |
| smp_rdy | output | 1 | Block accepts a sample or flush this cycle |
| flush | input | 1 | Request to close the open run and complete the packet |
| pkt_data | output | 128 | Packet: five records, then the sequence byte |
| pkt_valid | output | 1 | `pkt_data` holds a packet |
| pkt_ready | input | 1 | Downstream takes the packet |

## Verification
The corner that is hardest to reach from the ports is the sequence byte wrapping from 255 to 0. That needs more than 256 packets, each with five closed records. The stimulus reaches it with a long stream of samples that alternate between two values, so every sample closes a record. The count limit is reached with runs of exactly 256 and 257 equal samples. The back-pressure path is exercised by a mode in which `pkt_ready` is high only one cycle in four, so that a completed packet and a stalled sample source happen together.

// File: rtl/rle_pkg.sv
package rle_pkg;
  localparam int unsigned SMP_W = 16;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned SEQ_W = 8;
  localparam int unsigned REC_W = SMP_W + CNT_W;

  typedef logic [SMP_W-1:0] smp_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // count in the upper bits: the record's bytes read value-lo, value-hi, count
  typedef struct packed {
    cnt_t cnt;
    smp_t val;
  } rec_t;
endpackage

// File: rtl/rle_run_tracker.sv
module rle_run_tracker
  import rle_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic smp_acc,
  input  smp_t smp_val,
  input  logic flush_go,
  input  logic rec_rdy,
  output logic rec_vld,
  output rec_t rec_out
);
  localparam cnt_t CNT_MAX = {CNT_W{1'b1}};

  logic open_q;
  smp_t val_q;
  cnt_t cnt_q;
  logic same, sat;

  assign same    = (smp_val == val_q);
  assign sat     = (cnt_q == CNT_MAX);
  assign rec_vld = open_q && ((smp_acc && (!same || sat)) || flush_go);
  assign rec_out = '{cnt: cnt_q, val: val_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      val_q  <= '0;
      cnt_q  <= '0;
    end else if (flush_go) begin
      open_q <= 1'b0;
    end else if (smp_acc) begin
      if (!open_q || !same || sat) begin
        open_q <= 1'b1;
        val_q  <= smp_val;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_EMIT_ROOM: assert property (@(posedge clk) disable iff (rst)
    rec_vld |-> rec_rdy); // R7

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (smp_acc && !flush_go && open_q && sat) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/rle_pkt_assembler.sv
module rle_pkt_assembler
  import rle_pkg::*;
#(
  parameter int unsigned RECS  = 5,
  parameter int unsigned PKT_W = RECS * REC_W + SEQ_W
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_vld,
  input  rec_t             rec_in,
  input  logic             flush_go,
  output logic             rec_rdy,
  output logic [PKT_W-1:0] pkt_data,
  output logic             pkt_valid,
  input  logic             pkt_ready
);
  localparam int unsigned SLOT_W = (RECS > 1) ? $clog2(RECS) : 1;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(RECS - 1);

  rec_t              buf_q [RECS];
  logic [SLOT_W-1:0] slot_q, slot_nxt;
  logic [SEQ_W-1:0]  seq_q;
  logic              pad_q, pad_nxt;
  smp_t              last_q;
  logic              room, ins, load;
  rec_t              ins_rec;
  logic [PKT_W-1:0]  pkt_nxt;

  assign room    = (slot_q != LAST) || !pkt_valid;
  assign rec_rdy = room && !pad_q;
  assign ins     = rec_vld || (pad_q && room);
  assign ins_rec = pad_q ? '{cnt: '0, val: last_q} : rec_in;
  assign load    = ins && (slot_q == LAST);
  assign slot_nxt = !ins ? slot_q : ((slot_q == LAST) ? '0 : slot_q + 1'b1);
  assign pad_nxt  = (flush_go || pad_q) && (slot_nxt != '0);

  always_comb begin
    pkt_nxt = '0;
    for (int i = 0; i < RECS - 1; i++) pkt_nxt[i*REC_W +: REC_W] = buf_q[i];
    pkt_nxt[(RECS-1)*REC_W +: REC_W] = ins_rec;
    pkt_nxt[PKT_W-1 -: SEQ_W] = seq_q;
  end

  always_ff @(posedge clk) begin
    if (ins) buf_q[slot_q] <= ins_rec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q    <= '0;
      seq_q     <= '0;
      pad_q     <= 1'b0;
      last_q    <= '0;
      pkt_valid <= 1'b0;
      pkt_data  <= '0;
    end else begin
      slot_q <= slot_nxt;
      pad_q  <= pad_nxt;
      if (ins) last_q <= ins_rec.val;
      if (load) begin
        pkt_data  <= pkt_nxt;
        pkt_valid <= 1'b1;
        seq_q     <= seq_q + 1'b1;
      end else if (pkt_ready) begin
        pkt_valid <= 1'b0;
      end
    end
  end

  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data))); // R7

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_q <= LAST); // R4

  AST_PAD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    $fell(pad_q) |-> (slot_q == '0)); // R6
endmodule

// File: rtl/rle_sample_packer.sv
module rle_sample_packer
  import rle_pkg::*;
#(
  parameter int unsigned RECS  = 5,
  parameter int unsigned PKT_W = RECS * REC_W + SEQ_W
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [SMP_W-1:0] smp_in,
  output logic             smp_rdy,
  input  logic             flush,
  output logic [PKT_W-1:0] pkt_data,
  output logic             pkt_valid,
  input  logic             pkt_ready
);
  logic smp_acc, flush_go, rec_vld, rec_rdy;
  rec_t rec;

  assign smp_rdy  = rec_rdy;
  assign smp_acc  = cap_en && rec_rdy;
  assign flush_go = flush && !cap_en && rec_rdy;

  rle_run_tracker u_run (
    .clk(clk), .rst(rst), .smp_acc(smp_acc), .smp_val(smp_in),
    .flush_go(flush_go), .rec_rdy(rec_rdy), .rec_vld(rec_vld), .rec_out(rec)
  );

  rle_pkt_assembler #(.RECS(RECS), .PKT_W(PKT_W)) u_asm (
    .clk(clk), .rst(rst), .rec_vld(rec_vld), .rec_in(rec),
    .flush_go(flush_go), .rec_rdy(rec_rdy), .pkt_data(pkt_data),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready)
  );

  AST_RST_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!pkt_valid && smp_rdy)); // R8
endmodule

// File: tb/rle_sample_packer_tb_top.sv
module rle_sample_packer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_en = 1'b0;
  logic [15:0] smp_in = '0;
  logic flush = 1'b0;
  logic pkt_ready = 1'b1;
  logic smp_rdy, pkt_valid;
  logic [127:0] pkt_data;

  always #4 clk = ~clk;

  rle_sample_packer dut_i (
    .clk(clk), .rst(rst), .cap_en(cap_en), .smp_in(smp_in), .smp_rdy(smp_rdy),
    .flush(flush), .pkt_data(pkt_data), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready)
  );

  int errors = 0, checks = 0, cyc = 0, pkts = 0;
  logic bp_mode = 1'b0;
  string cur_tag = "R2";
  logic [23:0] exp_q[$];
  logic [7:0] exp_seq = 0;
  logic m_open = 0;
  logic [15:0] m_val = 0;
  logic [7:0] m_cnt = 0;
  int m_total = 0;
  logic prev_stall = 0;
  logic [127:0] prev_data = '0;

  // run table: {length, value}
  localparam logic [31:0] RUN_TBL [10] = '{
    {16'd1, 16'h0001}, {16'd3, 16'h0002}, {16'd1, 16'h0001}, {16'd7, 16'hBEEF},
    {16'd2, 16'h0000}, {16'd1, 16'hFFFF}, {16'd5, 16'h8000}, {16'd4, 16'h00FF},
    {16'd1, 16'h0100}, {16'd9, 16'h1357}};

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_rec(input logic [15:0] v, input logic [7:0] c);
    exp_q.push_back({c, v});
    m_total++;
  endtask

  task automatic send(input logic [15:0] v);
    @(negedge clk);
    cap_en = 1'b1; flush = 1'b0; smp_in = v;
    while (!smp_rdy) @(negedge clk);
    if (!m_open) begin m_open = 1; m_val = v; m_cnt = 0; end
    else if (v == m_val && m_cnt != 8'hFF) m_cnt++;
    else begin push_rec(m_val, m_cnt); m_val = v; m_cnt = 0; end
  endtask

  task automatic do_flush();
    @(negedge clk);
    cap_en = 1'b0; flush = 1'b1;
    while (!smp_rdy) @(negedge clk);
    if (m_open) begin push_rec(m_val, m_cnt); m_open = 0; end
    while (m_total % 5 != 0) push_rec(m_val, 8'h00);
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || pkt_valid) && n < 20000) begin @(negedge clk); n++; end
    chk(exp_q.size() == 0, {cur_tag, " drain"}, 128'(exp_q.size()), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    #1 pkt_ready = bp_mode ? (cyc % 4 == 0) : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) chk(pkt_valid && pkt_data == prev_data, "R7 hold", pkt_data, prev_data);
      prev_stall = pkt_valid && !pkt_ready;
      prev_data  = pkt_data;
      if (pkt_valid && pkt_ready) begin
        logic [127:0] e;
        e = '0;
        if (exp_q.size() < 5) begin
          chk(0, {cur_tag, " unexpected packet"}, pkt_data, 0);
        end else begin
          for (int k = 0; k < 5; k++) e[24*k +: 24] = exp_q.pop_front();
          e[127:120] = exp_seq;
          chk(pkt_data[119:0] == e[119:0], {cur_tag, " R1 R4 records"}, pkt_data, e);
          chk(pkt_data[127:120] == exp_seq, "R5 seq", 128'(pkt_data[127:120]), 128'(exp_seq));
        end
        exp_seq++;
        pkts++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!pkt_valid && smp_rdy, "R8 reset", {pkt_valid, smp_rdy}, 2'b01);

    // R10 idle flush
    cur_tag = "R10";
    do_flush();
    repeat (10) @(negedge clk);
    chk(pkts == 0, "R10 no packet", 128'(pkts), 0);

    // R2 table of runs
    cur_tag = "R2";
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < int'(RUN_TBL[i][31:16]); j++) send(RUN_TBL[i][15:0]);
    do_flush();
    drain();

    // R3 count limit
    cur_tag = "R3";
    for (int j = 0; j < 256; j++) send(16'hA5A5);
    for (int j = 0; j < 257; j++) send(16'h1234);
    do_flush();
    drain();

    // R9 samples ignored while cap_en low
    cur_tag = "R9";
    for (int j = 0; j < 3; j++) send(16'h7777);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk); cap_en = 1'b0; smp_in = 16'(j * 16'h1111);
    end
    for (int j = 0; j < 2; j++) send(16'h7777);
    send(16'h0042);
    do_flush();
    drain();

    // R6 partial packet flush
    cur_tag = "R6";
    send(16'hC0DE); send(16'hC0DE); send(16'hD00D);
    do_flush();
    drain();

    // R7 back-pressure
    cur_tag = "R7";
    bp_mode = 1'b1;
    for (int j = 0; j < 60; j++) send((j % 3 == 0) ? 16'h0F0F : 16'(j));
    do_flush();
    drain();
    bp_mode = 1'b0;

    // R5 sequence wrap
    cur_tag = "R5";
    for (int j = 0; j < 1320; j++) send(j[0] ? 16'hFFFF : 16'h0000);
    do_flush();
    drain();
    chk(pkts > 256, "R5 wrap reached", 128'(pkts), 257);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule